// File: doc/BRIEF.md
# Layered Reset Generator

This block turns a set of reset causes into four separately timed reset outputs: one for the processor core, one for the peripheral and system logic, one for the battery-backed domain and one for debug logic. The causes are a power-on signal, an external active-low reset pin, expiry pulses from two independent watchdogs, a low-power-management request and two software requests. One software request resets the whole system. The other resets the core only, which leaves peripheral state such as an output pin that powers another board unchanged. Every reset output is held for a programmable minimum number of cycles and is released on a clock edge.

A sticky flag records each system reset cause. The flags survive system resets, so software can find out after restart why the restart happened. Software clears the flags through a small write port. Through the same port it can request a reset of the backup domain. The backup domain is otherwise reset only when its own supply (main and battery together) has gone and then returns. An ordinary power-on leaves the backup domain alone. Debug logic is reset by power-on only.

Top module: `rstgen`

## Requirements
- R1: While `por_n` is low, all of `core_rst_n`, `sys_rst_n` and `dbg_rst_n` are low and `cause_flags` reads 6'b000001. After `por_n` rises, these three outputs go high on the 18th rising clock edge (2 synchronizer edges plus STRETCH_LEN=16).
- R2: The pin `ext_rst_n` passes through a two-flop synchronizer that it clears asynchronously. A low pin drives `sys_rst_n` and `core_rst_n` low at the first rising edge after the fall. Both outputs go high on the 18th rising edge after the pin rises. Flag bit 1 is set.
- R3: A one-cycle high on `wwdg_expired`, `iwdg_expired` or `lpm_rst_req` that is sampled at edge k drives `sys_rst_n` and `core_rst_n` low from edge k. Both outputs go high at edge k+16. The cause sets flag bit 2, 3 or 5 respectively.
- R4: A pulse on `sw_sys_req` that is sampled at edge k acts as a system reset cause at edge k+SW_DELAY (default 4). From there it behaves as in R3 and sets flag bit 4.
- R5: A software request that arrives while an earlier request of the same kind is still waiting is ignored.
- R6: A pulse on `sw_core_req` drives only `core_rst_n` low, after the same delay as R4. `sys_rst_n`, `bkp_rst_n` and the flags are unaffected. `core_rst_n` is low whenever `sys_rst_n` is low.
- R7: A reset output stays low until 16 cycles have passed after the last trigger. A new trigger during that time restarts the count.
- R8: Flag bits are 0 power-on, 1 pin, 2 window watchdog, 3 independent watchdog, 4 software, 5 low-power. A flag stays set through system resets until it is cleared.
- R9: A write (`cfg_we` high) with `cfg_wdata[0]`=1 clears all flags on the next edge. A cause that fires in the same cycle still sets its own flag.
- R10: A write with `cfg_wdata[1]`=1 drives `bkp_rst_n` low for 16 cycles and leaves the other outputs and the flags unchanged.
- R11: `bkp_rst_n` is low while `bkp_pwr_ok` is low and goes high on the 18th edge after it returns. Power-on alone never asserts `bkp_rst_n`.
- R12: `dbg_rst_n` is asserted by power-on only and no other cause touches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| bkp_pwr_ok | input | 1 | Backup-domain supply good; low when main and battery are both lost |
| wwdg_expired | input | 1 | Window watchdog expiry pulse |
| iwdg_expired | input | 1 | Independent watchdog expiry pulse |
| lpm_rst_req | input | 1 | Low-power-management reset request pulse |
| sw_sys_req | input | 1 | Software system reset request pulse |
| sw_core_req | input | 1 | Software core-only reset request pulse |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 2 | Bit 0 clears flags, bit 1 requests a backup reset |
| core_rst_n | output | 1 | Core reset, active low |
| sys_rst_n | output | 1 | System/peripheral reset, active low |
| bkp_rst_n | output | 1 | Backup-domain reset, active low |
| dbg_rst_n | output | 1 | Debug reset, active low |
| cause_flags | output | 6 | Sticky reset-cause flags |

## Verification
A bad stretch counter shows up as a reset output that goes high earlier or later than the 16-cycle window. A cycle-exact comparison catches this at the first wrong edge. A wrong software delay counter moves the assertion of `sys_rst_n` or `core_rst_n` off edge k+SW_DELAY, and the error is visible as soon as that edge passes. Errors in the flag register appear on `cause_flags` one edge after the cause, clear or power-on that should have changed it. Errors in the domain steering appear on the first cause that reaches a domain it must not touch, such as a backup write or a core-only request.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int unsigned NUM_CAUSE = 6;
  localparam int unsigned C_POR = 0;
  localparam int unsigned C_PIN = 1;
  localparam int unsigned C_WWD = 2;
  localparam int unsigned C_IWD = 3;
  localparam int unsigned C_SW  = 4;
  localparam int unsigned C_LPM = 5;

  localparam int unsigned NUM_DOM = 4;
  localparam int unsigned D_CORE = 0;
  localparam int unsigned D_SYS  = 1;
  localparam int unsigned D_BKP  = 2;
  localparam int unsigned D_DBG  = 3;

  localparam int unsigned NUM_SYNC = 3;
  localparam int unsigned S_POR = 0;
  localparam int unsigned S_PIN = 1;
  localparam int unsigned S_BKP = 2;

  typedef logic [NUM_CAUSE-1:0] cause_t;

  // value of the flag register right after power-on
  function automatic cause_t flags_after_por();
    cause_t v;
    v = '0;
    v[C_POR] = 1'b1;
    return v;
  endfunction

  // sticky update: clear first, causes of the same cycle win
  function automatic cause_t flags_merge(cause_t cur, cause_t ev, logic clr);
    cause_t base;
    base = clr ? cause_t'(0) : cur;
    return base | ev;
  endfunction
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic out_n
);
  logic [STAGES-1:0] chain_q;

  // assertion is asynchronous, release ripples through the chain
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign out_n = chain_q[STAGES-1];
endmodule

// File: rtl/rstgen_stretch.sv
module rstgen_stretch #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic trig,
  output logic rst_n_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  function automatic logic [CW-1:0] next_count(logic [CW-1:0] cur, logic hit);
    if (hit)      return LOAD;
    if (cur != 0) return cur - CW'(1);
    return cur;
  endfunction

  always_comb cnt_d = next_count(cnt_q, trig);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q   <= LOAD;
      rst_n_o <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rst_n_o <= (cnt_d == 0);
    end
  end

  // R7: a trigger always leaves the output asserted on the next cycle
  p_trig_holds_r7: assert property (@(posedge clk) disable iff (!arst_n)
    trig |=> !rst_n_o);
  // R7: release only follows a cycle without a trigger
  p_release_quiet_r7: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_o) |-> $past(!trig));
endmodule

// File: rtl/rstgen_swdelay.sv
module rstgen_swdelay #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  output logic fire
);
  generate
    if (DELAY == 0) begin : g_direct
      logic unused_inputs;
      assign unused_inputs = clk ^ arst_n;
      assign fire = req;
    end else begin : g_timed
      localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
      logic          pending_q;
      logic [CW-1:0] cnt_q;
      logic [7:0]    chk_age_q;

      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          pending_q <= 1'b0;
          cnt_q     <= '0;
        end else if (pending_q) begin
          if (cnt_q == 0) pending_q <= 1'b0;
          else            cnt_q     <= cnt_q - CW'(1);
        end else if (req) begin
          pending_q <= 1'b1;
          cnt_q     <= CW'(DELAY - 1);
        end
      end

      assign fire = pending_q && (cnt_q == 0);

      // checker-side age counter, independent of the down counter
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                chk_age_q <= '0;
        else if (!pending_q && req) chk_age_q <= 8'd1;
        else if (pending_q)         chk_age_q <= chk_age_q + 8'd1;
      end

      // R4: fire comes exactly DELAY edges after acceptance
      p_delay_exact_r4: assert property (@(posedge clk) disable iff (!arst_n)
        fire |-> (chk_age_q == 8'(DELAY)));
      // R5: a request while waiting does not restart the wait
      p_no_restart_r5: assert property (@(posedge clk) disable iff (!arst_n)
        (pending_q && (cnt_q != 0) && req) |=> (chk_age_q != 8'd1));
    end
  endgenerate
endmodule

// File: rtl/rstgen_flags.sv
module rstgen_flags
  import rstgen_pkg::*;
(
  input  logic   clk,
  input  logic   arst_n,
  input  cause_t ev,
  input  logic   clr,
  output cause_t flags_o
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) flags_o <= flags_after_por();
    else         flags_o <= flags_merge(flags_o, ev, clr);
  end

  // R8: a firing cause is recorded on the next cycle
  p_cause_set_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (ev != '0) |=> ((flags_o & $past(ev)) == $past(ev)));
  // R8: with no cause and no clear the flags hold
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (!clr && ev == '0) |=> $stable(flags_o));
  // R9: a clear with no cause empties the register
  p_clear_all_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (clr && ev == '0) |=> (flags_o == '0));
endmodule

// File: rtl/rstgen.sv
module rstgen
  import rstgen_pkg::*;
#(
  parameter int unsigned STRETCH_LEN = 16,
  parameter int unsigned SW_DELAY    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic       bkp_pwr_ok,
  input  logic       wwdg_expired,
  input  logic       iwdg_expired,
  input  logic       lpm_rst_req,
  input  logic       sw_sys_req,
  input  logic       sw_core_req,
  input  logic       cfg_we,
  input  logic [1:0] cfg_wdata,
  output logic       core_rst_n,
  output logic       sys_rst_n,
  output logic       bkp_rst_n,
  output logic       dbg_rst_n,
  output logic [5:0] cause_flags
);
  localparam int unsigned WB_CLEAR  = 0;
  localparam int unsigned WB_BACKUP = 1;

  // synchronised reset sources
  logic [NUM_SYNC-1:0] sync_arst_n;
  logic [NUM_SYNC-1:0] sync_out_n;
  logic por_s_n, pin_s_n, bkp_s_n;

  assign sync_arst_n[S_POR] = por_n;
  assign sync_arst_n[S_PIN] = ext_rst_n & por_n;
  assign sync_arst_n[S_BKP] = bkp_pwr_ok;

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
    rstgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (sync_arst_n[g]),
      .out_n  (sync_out_n[g])
    );
  end

  assign por_s_n = sync_out_n[S_POR];
  assign pin_s_n = sync_out_n[S_PIN];
  assign bkp_s_n = sync_out_n[S_BKP];

  // delayed software requests
  logic sw_sys_fire, sw_core_fire;

  rstgen_swdelay #(.DELAY(SW_DELAY)) u_sw_sys (
    .clk (clk), .arst_n (por_s_n), .req (sw_sys_req), .fire (sw_sys_fire)
  );
  rstgen_swdelay #(.DELAY(SW_DELAY)) u_sw_core (
    .clk (clk), .arst_n (por_s_n), .req (sw_core_req), .fire (sw_core_fire)
  );

  // named internal events
  cause_t cause_ev;
  logic   sys_any;
  logic   flag_clr;
  logic   bkp_wr;

  always_comb begin
    cause_ev        = '0;
    cause_ev[C_PIN] = !pin_s_n;
    cause_ev[C_WWD] = wwdg_expired;
    cause_ev[C_IWD] = iwdg_expired;
    cause_ev[C_SW]  = sw_sys_fire;
    cause_ev[C_LPM] = lpm_rst_req;
  end

  assign sys_any  = |cause_ev;
  assign flag_clr = cfg_we & cfg_wdata[WB_CLEAR];
  assign bkp_wr   = cfg_we & cfg_wdata[WB_BACKUP];

  // per-domain triggers and asynchronous sources
  logic [NUM_DOM-1:0] dom_trig;
  logic [NUM_DOM-1:0] dom_arst_n;
  logic [NUM_DOM-1:0] dom_rst_n;

  always_comb begin
    dom_trig           = '0;
    dom_trig[D_CORE]   = sys_any | sw_core_fire;
    dom_trig[D_SYS]    = sys_any;
    dom_trig[D_BKP]    = bkp_wr;
    dom_trig[D_DBG]    = 1'b0;
    dom_arst_n         = '0;
    dom_arst_n[D_CORE] = por_s_n;
    dom_arst_n[D_SYS]  = por_s_n;
    dom_arst_n[D_BKP]  = bkp_s_n;
    dom_arst_n[D_DBG]  = por_s_n;
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    rstgen_stretch #(.LEN(STRETCH_LEN)) u_stretch (
      .clk     (clk),
      .arst_n  (dom_arst_n[d]),
      .trig    (dom_trig[d]),
      .rst_n_o (dom_rst_n[d])
    );
  end

  assign core_rst_n = dom_rst_n[D_CORE];
  assign sys_rst_n  = dom_rst_n[D_SYS];
  assign bkp_rst_n  = dom_rst_n[D_BKP];
  assign dbg_rst_n  = dom_rst_n[D_DBG];

  cause_t flags_q;

  rstgen_flags u_flags (
    .clk     (clk),
    .arst_n  (por_s_n),
    .ev      (cause_ev),
    .clr     (flag_clr),
    .flags_o (flags_q)
  );

  assign cause_flags = flags_q;

  // R6: the core is always held while the system is held
  p_core_covers_sys_r6: assert property (@(posedge clk) disable iff (!por_s_n)
    !sys_rst_n |-> !core_rst_n);
  // R12: debug reset never outlasts the system reset after power-on
  p_dbg_por_only_r12: assert property (@(posedge clk) disable iff (!por_s_n)
    !dbg_rst_n |-> !sys_rst_n);
  // R4: a delayed software request reaches the system domain
  p_sw_reaches_sys_r4: assert property (@(posedge clk) disable iff (!por_s_n)
    sw_sys_fire |=> !sys_rst_n);
  // R10: a backup write alone does not disturb a running system
  p_bkp_isolated_r10: assert property (@(posedge clk) disable iff (!por_s_n)
    (bkp_wr && sys_rst_n && !sys_any) |=> sys_rst_n);
endmodule

// File: tb/rstgen_tb_top.sv
module rstgen_tb_top;
  localparam int LEN = 16;
  localparam int SWD = 4;
  localparam int WATCHDOG = 20000;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, ext_rst_n = 1'b1, bkp_pwr_ok = 1'b0;
  logic       wwdg_expired = 1'b0, iwdg_expired = 1'b0, lpm_rst_req = 1'b0;
  logic       sw_sys_req = 1'b0, sw_core_req = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_wdata = 2'b00;
  logic       core_rst_n, sys_rst_n, bkp_rst_n, dbg_rst_n;
  logic [5:0] cause_flags;

  always #10 clk = ~clk;

  rstgen #(.STRETCH_LEN(LEN), .SW_DELAY(SWD)) dut_i (
    .clk (clk), .por_n (por_n), .ext_rst_n (ext_rst_n), .bkp_pwr_ok (bkp_pwr_ok),
    .wwdg_expired (wwdg_expired), .iwdg_expired (iwdg_expired),
    .lpm_rst_req (lpm_rst_req), .sw_sys_req (sw_sys_req), .sw_core_req (sw_core_req),
    .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
    .core_rst_n (core_rst_n), .sys_rst_n (sys_rst_n), .bkp_rst_n (bkp_rst_n),
    .dbg_rst_n (dbg_rst_n), .cause_flags (cause_flags)
  );

  // ---------------- behavioural reference ----------------
  int m_core = LEN, m_sys = LEN, m_bkp = LEN, m_dbg = LEN;
  logic [5:0] m_flags = 6'b000001;
  bit m_p1 = 0, m_p2 = 0, m_e1 = 0, m_e2 = 0, m_b1 = 0, m_b2 = 0;
  int m_ts = 0, m_tc = 0;

  function automatic int tick(int c, bit hit);
    if (hit) return LEN;
    if (c > 0) return c - 1;
    return 0;
  endfunction

  function automatic bit wait_step(ref int t, input bit req);
    bit f = 0;
    if (SWD == 0) return req;
    if (t == 1) begin f = 1; t = 0; end
    else if (t > 1) t = t - 1;
    else if (req) t = SWD;
    return f;
  endfunction

  always @(posedge clk) begin
    bit pa, ea, ba, fs, fc, sysev;
    logic [5:0] ev;
    pa = !m_p2 || !por_n;
    ea = !m_e2 || !(ext_rst_n && por_n);
    ba = !m_b2 || !bkp_pwr_ok;
    fs = 0; fc = 0;
    if (pa) begin m_ts = 0; m_tc = 0; end
    else begin
      fs = wait_step(m_ts, sw_sys_req);
      fc = wait_step(m_tc, sw_core_req);
    end
    ev = {lpm_rst_req, fs, iwdg_expired, wwdg_expired, ea, 1'b0};
    sysev = |ev;
    if (pa) begin
      m_core = LEN; m_sys = LEN; m_dbg = LEN; m_flags = 6'b000001;
    end else begin
      m_core = tick(m_core, sysev || fc);
      m_sys  = tick(m_sys, sysev);
      m_dbg  = tick(m_dbg, 0);
      m_flags = ((cfg_we && cfg_wdata[0]) ? 6'b0 : m_flags) | ev;
    end
    if (ba) m_bkp = LEN;
    else    m_bkp = tick(m_bkp, cfg_we && cfg_wdata[1]);
    m_p2 = por_n ? m_p1 : 0;                  m_p1 = por_n;
    m_e2 = (por_n && ext_rst_n) ? m_e1 : 0;   m_e1 = por_n && ext_rst_n;
    m_b2 = bkp_pwr_ok ? m_b1 : 0;             m_b1 = bkp_pwr_ok;
  end

  // ---------------- comparison ----------------
  int    n_vec = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  bit    done = 0;

  always @(posedge clk) begin
    #5;
    if (!done) begin
      logic [9:0] act, exp;
      act = {core_rst_n, sys_rst_n, bkp_rst_n, dbg_rst_n, cause_flags};
      exp = {m_core == 0, m_sys == 0, m_bkp == 0, m_dbg == 0, m_flags};
      n_vec++;
      if (act !== exp) begin
        n_bad++;
        $display("FAIL %s cycle %0d: {core,sys,bkp,dbg,flags} actual %b expected %b",
                 cur_req, cyc, act, exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected below %0d",
               cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic wr(logic [1:0] d);
    @(negedge clk) begin cfg_we = 1'b1; cfg_wdata = d; end
    @(negedge clk) begin cfg_we = 1'b0; cfg_wdata = 2'b00; end
  endtask

  initial begin
    // R1 / R11: power-on together with loss of backup supply
    cur_req = "R1"; idle(5);
    @(negedge clk) begin por_n = 1'b1; bkp_pwr_ok = 1'b1; end
    idle(25);
    // R3: watchdogs and low-power request
    cur_req = "R3"; pulse(wwdg_expired); idle(20);
    pulse(iwdg_expired); idle(20);
    pulse(lpm_rst_req); idle(20);
    // R2: external pin held low for a few cycles
    cur_req = "R2"; @(negedge clk) ext_rst_n = 1'b0; idle(3);
    @(negedge clk) ext_rst_n = 1'b1; idle(25);
    // R7: retrigger inside the stretch window
    cur_req = "R7"; pulse(wwdg_expired); idle(7); pulse(iwdg_expired); idle(25);
    // R4: delayed software system reset
    cur_req = "R4"; pulse(sw_sys_req); idle(25);
    // R5: second request while waiting is dropped
    cur_req = "R5"; pulse(sw_sys_req); idle(1); pulse(sw_sys_req); idle(30);
    // R6: core-only software reset
    cur_req = "R6"; pulse(sw_core_req); idle(1); pulse(sw_core_req); idle(25);
    // R9: clear flags, then clear coinciding with a cause
    cur_req = "R9"; wr(2'b01); idle(3);
    @(negedge clk) begin cfg_we = 1'b1; cfg_wdata = 2'b01; lpm_rst_req = 1'b1; end
    @(negedge clk) begin cfg_we = 1'b0; cfg_wdata = 2'b00; lpm_rst_req = 1'b0; end
    idle(20);
    // R8: flags survive a system reset
    cur_req = "R8"; pulse(iwdg_expired); idle(20);
    // R10: backup reset by write, nothing else moves
    cur_req = "R10"; wr(2'b10); idle(5); wr(2'b10); idle(25);
    // R11: backup supply loss while running
    cur_req = "R11"; @(negedge clk) bkp_pwr_ok = 1'b0; idle(3);
    @(negedge clk) bkp_pwr_ok = 1'b1; idle(25);
    // R12: power-on with backup supply present resets debug, not backup
    cur_req = "R12"; @(negedge clk) por_n = 1'b0; idle(3);
    @(negedge clk) por_n = 1'b1; idle(25);
    pulse(sw_sys_req); idle(25);
    cur_req = "R1"; idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule